// File: doc/BRIEF.md
# Set/clear masked interrupt controller

This block collects sixteen level-sensitive interrupt inputs and drives a single interrupt request toward a processor. Software turns a source on through two kinds of register. The mask register gives one bit to each source. The priority registers give a four-bit field to each source they cover. A source that appears in more than one register passes its input on only when every register that covers it has it switched on. Registers that have both a set address and a clear address can be changed bit by bit, with no read-modify-write.

The processor finds out which source to serve through a combinational vector query. The block returns the vector of the lowest-numbered pending source, or nothing when the processor's interrupt mask level is 15. Slot 0 is reserved and never becomes pending. Every register resets to zero, so all sources start disabled.

Top module: `setclr_intc`

## Requirements
- R1: A write to a set address (mask register at 0x040, priority register 1 at 0x008) ORs the written data into that register.
- R2: A write to a clear address (mask register at 0x044, priority register 1 at 0x00C) clears the register bits that are 1 in the written data. A read at the clear address returns the register value.
- R3: Priority register 0 has a single address, 0x000. A write there replaces its whole value. Address 0x004 is not mapped and reads as 0. Any unmapped address reads as 0.
- R4: The address decode uses only addr_i[28:0], so any setting of addr_i[31:29] reaches the same register.
- R5: Mask bit (15 - k) enables source k, most significant bit first. For example, bit 14 is source 1, bit 7 is source 8 and bit 0 is source 15.
- R6: Priority register p holds four 4-bit fields in MSB-first order. Field j sits at bits [(3-j)*4+3 : (3-j)*4] and covers source 4p+j. A nonzero field value enables its source.
- R7: Sources 1 to 7 are referenced by both the mask register and a priority field, and need both to be on. Sources 8 to 15 are referenced only by the mask register.
- R8: A source is pending when its input is high and it is fully enabled. irq_o is high when at least one source is pending. irq_o follows an input change one clock edge later, and follows a register write two clock edges later.
- R9: When some source is pending and imask_i is not 15, vec_valid_o is 1 and vec_o = 0x200 + 0x20 * (index of the lowest-numbered pending source).
- R10: When imask_i is 15, or when no source is pending, vec_valid_o is 0 and vec_o is 0. irq_o is not affected by imask_i.
- R11: Source 0 is reserved. It never becomes pending, whatever its input and register bits are.
- R12: After reset, all registers read 0, irq_o is 0 and vec_valid_o is 0.
- R13: A priority field that changes from one nonzero value to another leaves its source enabled. A later write of 0 to that field disables the source, because the change was not counted as a second enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 32 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| src_i | input | 16 | Level inputs of the interrupt sources |
| imask_i | input | 4 | Processor interrupt mask level |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 12 | Vector of the selected source |
| vec_valid_o | output | 1 | vec_o is meaningful |

## Verification
The hardest state to reach from the ports is a source that is enabled through two registers whose enable count has already been moved by a change from one nonzero field value to another. The stimulus gets there in three steps. It sets the mask bit of source 1 first. Next it rewrites priority register 0 from field value 3 to field value 5. Last it writes 0 to the field and expects the source to turn off, which shows the count stayed right. The aliased upper address bits are covered by doing set writes and reads through high-bit addresses. The reserved slot is covered by switching on both of its references with its input held high.

// File: rtl/setclr_intc_pkg.sv
package setclr_intc_pkg;

  // bit position of mask slot k, most significant bit first
  function automatic int unsigned mask_bit(int unsigned slot, int unsigned reg_w);
    return reg_w - 1 - slot;
  endfunction

  // low bit of priority field j, fields ordered most significant first
  function automatic int unsigned field_lsb(int unsigned j, int unsigned nf, int unsigned fw);
    return (nf - 1 - j) * fw;
  endfunction

  // number of register references a source has: the mask bit plus an optional field
  function automatic int unsigned ref_total(int unsigned s, int unsigned nprio, int unsigned nf);
    return 1 + ((s < nprio * nf) ? 1 : 0);
  endfunction

  function automatic int unsigned vec_of(int unsigned s, int unsigned base, int unsigned step);
    return base + s * step;
  endfunction

endpackage

// File: rtl/setclr_intc_regs.sv
module setclr_intc_regs
  import setclr_intc_pkg::*;
#(
  parameter int unsigned NSRC       = 16,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned FW         = 4,
  parameter int unsigned NPRIO      = 2,
  parameter logic [1:0]  PRIO_DUAL  = 2'b10,
  parameter int unsigned MASK_SET_A = 'h40,
  parameter int unsigned MASK_CLR_A = 'h44,
  parameter int unsigned PRIO_A     = 'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [NSRC-1:0]  en_inc_o,
  output logic [NSRC-1:0]  en_dec_o
);
  localparam int unsigned NF = REG_W / FW;

  logic [REG_W-1:0] mask_q, mask_nx;
  logic [REG_W-1:0] prio_q  [NPRIO];
  logic [REG_W-1:0] prio_nx [NPRIO];
  logic [28:0]      a7;
  logic             hit_ms, hit_mc;
  logic [NPRIO-1:0] hit_ps, hit_pc;

  assign a7 = addr_i[28:0];

  always_comb begin
    hit_ms = (a7 == 29'(MASK_SET_A));
    hit_mc = (a7 == 29'(MASK_CLR_A));
    for (int p = 0; p < NPRIO; p++) begin
      hit_ps[p] = (a7 == 29'(PRIO_A + p * 8));
      hit_pc[p] = PRIO_DUAL[p] && (a7 == 29'(PRIO_A + p * 8 + 4));
    end
  end

  always_comb begin
    mask_nx = mask_q;
    if (wr_i && hit_ms)      mask_nx = mask_q | wdata_i;
    else if (wr_i && hit_mc) mask_nx = mask_q & ~wdata_i;
    for (int p = 0; p < NPRIO; p++) begin
      prio_nx[p] = prio_q[p];
      if (wr_i && hit_ps[p])      prio_nx[p] = PRIO_DUAL[p] ? (prio_q[p] | wdata_i) : wdata_i;
      else if (wr_i && hit_pc[p]) prio_nx[p] = prio_q[p] & ~wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int p = 0; p < NPRIO; p++) prio_q[p] <= '0;
    end else begin
      mask_q <= mask_nx;
      for (int p = 0; p < NPRIO; p++) prio_q[p] <= prio_nx[p];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ms || hit_mc) rdata_o = mask_q;
    for (int p = 0; p < NPRIO; p++)
      if (hit_ps[p] || hit_pc[p]) rdata_o = prio_q[p];
  end

  // per-source enable deltas, raised only for references whose on/off state flips
  for (genvar s = 0; s < NSRC; s++) begin : g_delta
    if (s == 0) begin : g_rsvd
      assign en_inc_o[s] = 1'b0;
      assign en_dec_o[s] = 1'b0;
    end else begin : g_src
      localparam int unsigned MB = mask_bit(s, REG_W);
      logic m_on, m_nx, p_on, p_nx;
      assign m_on = mask_q[MB];
      assign m_nx = mask_nx[MB];
      if (s < NPRIO * NF) begin : g_fld
        localparam int unsigned P = s / NF;
        localparam int unsigned L = field_lsb(s % NF, NF, FW);
        assign p_on = |prio_q[P][L +: FW];
        assign p_nx = |prio_nx[P][L +: FW];
      end else begin : g_nofld
        assign p_on = 1'b0;
        assign p_nx = 1'b0;
      end
      assign en_inc_o[s] = (!m_on && m_nx) || (!p_on && p_nx);
      assign en_dec_o[s] = (m_on && !m_nx) || (p_on && !p_nx);
    end
  end

  // R1
  mask_set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_ms) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R2
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_mc) |=> ((mask_q & $past(wdata_i)) == '0));
  // R13
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_inc_o & en_dec_o) == '0));

endmodule

// File: rtl/setclr_intc_track.sv
module setclr_intc_track
  import setclr_intc_pkg::*;
#(
  parameter int unsigned NSRC  = 16,
  parameter int unsigned NF    = 4,
  parameter int unsigned NPRIO = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] en_inc_i,
  input  logic [NSRC-1:0] en_dec_i,
  output logic [NSRC-1:0] en_o
);
  localparam int unsigned CW = 2;

  for (genvar s = 0; s < NSRC; s++) begin : g_cnt
    if (s == 0) begin : g_rsvd
      assign en_o[s] = 1'b0;
    end else begin : g_src
      localparam int unsigned REFS = ref_total(s, NPRIO, NF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (en_inc_i[s]) cnt_q <= cnt_q + 1'b1;
        else if (en_dec_i[s]) cnt_q <= cnt_q - 1'b1;
      end
      assign en_o[s] = (cnt_q == CW'(REFS));

      // R7
      refs_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(REFS));
    end
  end

endmodule

// File: rtl/setclr_intc_arb.sv
module setclr_intc_arb
  import setclr_intc_pkg::*;
#(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned VW       = 12,
  parameter int unsigned VEC_BASE = 'h200,
  parameter int unsigned VEC_STEP = 'h20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [3:0]      imask_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic            vec_valid_o
);
  localparam int unsigned CNTW = $clog2(NSRC + 1);
  localparam int unsigned IW   = $clog2(NSRC);

  logic [NSRC-1:0] pend_d, pend_q;
  logic [CNTW-1:0] pend_cnt;
  logic            found;
  logic [IW-1:0]   idx;

  assign pend_d = src_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_cnt <= '0;
    end else begin
      pend_q   <= pend_d;
      pend_cnt <= CNTW'($countones(pend_d));
    end
  end

  assign irq_o = (pend_cnt != '0);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign vec_valid_o = found && (imask_i != 4'hF);
  assign vec_o       = vec_valid_o ? VW'(vec_of(idx, VEC_BASE, VEC_STEP)) : '0;

  // R8
  irq_on_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |-> irq_o);
  // R8
  irq_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> !irq_o);
  // R11
  slot0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0]);
  // R10
  mask15_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_i == 4'hF) |-> !vec_valid_o);

endmodule

// File: rtl/setclr_intc.sv
module setclr_intc
  import setclr_intc_pkg::*;
#(
  parameter int unsigned NSRC       = 16,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned FW         = 4,
  parameter int unsigned NPRIO      = 2,
  parameter logic [1:0]  PRIO_DUAL  = 2'b10,
  parameter int unsigned MASK_SET_A = 'h40,
  parameter int unsigned MASK_CLR_A = 'h44,
  parameter int unsigned PRIO_A     = 'h00,
  parameter int unsigned VW         = 12,
  parameter int unsigned VEC_BASE   = 'h200,
  parameter int unsigned VEC_STEP   = 'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [NSRC-1:0]  src_i,
  input  logic [3:0]       imask_i,
  output logic             irq_o,
  output logic [VW-1:0]    vec_o,
  output logic             vec_valid_o
);
  localparam int unsigned NF = REG_W / FW;

  logic [NSRC-1:0] en_inc, en_dec, en;

  setclr_intc_regs #(
    .NSRC(NSRC), .REG_W(REG_W), .FW(FW), .NPRIO(NPRIO), .PRIO_DUAL(PRIO_DUAL),
    .MASK_SET_A(MASK_SET_A), .MASK_CLR_A(MASK_CLR_A), .PRIO_A(PRIO_A)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .en_inc_o(en_inc), .en_dec_o(en_dec)
  );

  setclr_intc_track #(.NSRC(NSRC), .NF(NF), .NPRIO(NPRIO)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_inc_i(en_inc), .en_dec_i(en_dec), .en_o(en)
  );

  setclr_intc_arb #(
    .NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .en_i(en), .imask_i(imask_i),
    .irq_o(irq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

endmodule

// File: tb/tb_setclr_intc.sv
`timescale 1ns/1ps
module tb_setclr_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] src = '0;
  logic [3:0]  imask = '0;
  logic        irq;
  logic [11:0] vec;
  logic        vvalid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  setclr_intc dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .imask_i(imask), .irq_o(irq),
    .vec_o(vec), .vec_valid_o(vvalid)
  );

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [15:0] d;
    logic [15:0] s;
    logic [3:0]  im;
    logic [15:0] rd;
    logic        iq;
    logic        vv;
    logic [11:0] vc;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 32'h0000_0040, 16'h4000, 16'h0002, 4'h0, 16'h4000, 1'b0, 1'b0, 12'h000}, // R1 R5 R7: s1 lacks field
    '{1'b1, 32'h0000_0000, 16'h0300, 16'h0002, 4'h0, 16'h0300, 1'b1, 1'b1, 12'h220}, // R3 R6 R8 R9
    '{1'b1, 32'h0000_0040, 16'h0080, 16'h0102, 4'h0, 16'h4080, 1'b1, 1'b1, 12'h220}, // R1 R7 R9 lowest wins
    '{1'b1, 32'h0000_0044, 16'h4000, 16'h0102, 4'h0, 16'h0080, 1'b1, 1'b1, 12'h300}, // R2 R7
    '{1'b0, 32'hA000_0040, 16'h0000, 16'h0102, 4'hF, 16'h0080, 1'b1, 1'b0, 12'h000}, // R4 R10
    '{1'b1, 32'h0000_0008, 16'h00F0, 16'h0102, 4'h0, 16'h00F0, 1'b1, 1'b1, 12'h300}, // R1 R6
    '{1'b1, 32'hE000_0040, 16'h0200, 16'h0040, 4'h0, 16'h0280, 1'b1, 1'b1, 12'h2C0}, // R4 R5 R6
    '{1'b1, 32'h0000_000C, 16'h0030, 16'h0040, 4'h0, 16'h00C0, 1'b1, 1'b1, 12'h2C0}, // R2 R13
    '{1'b1, 32'h0000_000C, 16'h00C0, 16'h0040, 4'h0, 16'h0000, 1'b0, 1'b0, 12'h000}, // R2 R13
    '{1'b1, 32'h0000_0040, 16'h8000, 16'h0001, 4'h0, 16'h8280, 1'b0, 1'b0, 12'h000}, // R11
    '{1'b1, 32'h0000_0000, 16'h7000, 16'h0001, 4'h0, 16'h7000, 1'b0, 1'b0, 12'h000}, // R3 R11
    '{1'b0, 32'h0000_0004, 16'h0000, 16'h0000, 4'h0, 16'h0000, 1'b0, 1'b0, 12'h000}, // R3 unmapped
    '{1'b1, 32'h0000_0040, 16'h0001, 16'h8000, 4'h0, 16'h8281, 1'b1, 1'b1, 12'h3E0}, // R5 slot 15
    '{1'b0, 32'h0000_0040, 16'h0000, 16'h8100, 4'h0, 16'h8281, 1'b1, 1'b1, 12'h300}, // R9
    '{1'b1, 32'h0000_0040, 16'h4000, 16'h0002, 4'h0, 16'hC281, 1'b0, 1'b0, 12'h000}, // R7
    '{1'b1, 32'h0000_0000, 16'h7300, 16'h0002, 4'h0, 16'h7300, 1'b1, 1'b1, 12'h220}, // R13
    '{1'b1, 32'h0000_0000, 16'h7500, 16'h0002, 4'h0, 16'h7500, 1'b1, 1'b1, 12'h220}, // R13
    '{1'b1, 32'h0000_0000, 16'h7000, 16'h0002, 4'h0, 16'h7000, 1'b0, 1'b0, 12'h000}  // R13
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic outputs(input string tag, input logic [15:0] erd, input logic eiq,
                         input logic evv, input logic [11:0] evc);
    check({tag, " rdata (R1 R2 R3 R4)"}, 32'(rdata), 32'(erd));
    check({tag, " irq (R7 R8 R11)"}, 32'(irq), 32'(eiq));
    check({tag, " vec_valid (R9 R10)"}, 32'(vvalid), 32'(evv));
    check({tag, " vec (R5 R6 R9 R13)"}, 32'(vec), 32'(evc));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    addr = 32'h40;
    #1 check("R12 mask after reset", 32'(rdata), 32'h0);
    addr = 32'h0;
    #1 check("R12 prio0 after reset", 32'(rdata), 32'h0);
    check("R12 irq after reset", 32'(irq), 32'h0);
    check("R12 vec_valid after reset", 32'(vvalid), 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      wr = TBL[i].w; addr = TBL[i].a; wdata = TBL[i].d;
      src = TBL[i].s; imask = TBL[i].im;
      @(negedge clk);
      wr = 1'b0;
      @(negedge clk);
      outputs($sformatf("step %0d", i), TBL[i].rd, TBL[i].iq, TBL[i].vv, TBL[i].vc);
    end

    // R8: input edge reaches irq after one clock edge (source 8 is enabled by mask only)
    @(negedge clk);
    src = 16'h0000;
    @(negedge clk);
    check("R8 irq idle", 32'(irq), 32'h0);
    src = 16'h0100;
    @(negedge clk);
    check("R8 irq one edge after input", 32'(irq), 32'h1);
    check("R9 vec of source 8", 32'(vec), 32'h300);
    src = 16'h0000;
    @(negedge clk);
    check("R8 irq drops one edge after input", 32'(irq), 32'h0);

    // R12: reset in mid run clears registers and enables
    src = 16'h0100;
    rst_n = 1'b0;
    @(negedge clk);
    addr = 32'h40;
    #1 check("R12 mask cleared by reset", 32'(rdata), 32'h0);
    check("R12 irq low in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 source disabled after reset", 32'(irq), 32'h0);
    check("R12 vec_valid low after reset", 32'(vvalid), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule